// File: doc/BRIEF.md
# AUX Transaction Sequencer

This block carries a single DisplayPort AUX transaction from a requester through to an abstracted AUX PHY and then reports how it ended. A requester offers a command on a valid/ready handshake. The command has a 4-bit type, a 20-bit address, a byte count of 1 to 16 and up to 16 bytes of write data. The block then works through a fixed sequence:

1. It waits for the PHY to go quiet.
2. It requests ownership of the channel and waits for the grant.
3. It checks that a sink is present.
4. It makes the attempt: a reset pulse on the channel, then a start pulse, then a wait for the done flag.

An attempt fails when any bit of the error-status word is nonzero. A failed attempt is repeated up to a fixed limit, and every repeat begins with a microsecond back-off.

All waits are measured in microseconds. The microsecond tick comes from a divider of the system clock, and each wait is bounded. When the transaction ends, the block releases channel ownership and raises a one-cycle response. The response carries a result code and, for reads, only the bytes that were requested.

Top module: `aux_xact_seq`

## Requirements
- R1: A command is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, and it falls in the cycle after acceptance.
- R2: Before taking the channel, the block waits up to WAIT_US microseconds for `phy_busy` to go low. If it stays high, the response is BUSY (code 1) and no start pulse is issued.
- R3: Ownership request `phy_own_req` is held while the block waits up to WAIT_US microseconds for `phy_own_gnt`. If the grant does not come, the response is BUSY (code 1) and the request is dropped.
- R4: If `phy_sink` is low once the grant has been seen, the response is NO_SINK (code 2) and no start pulse is issued.
- R5: While a start pulse is issued, the following outputs hold the command:
  - `phy_cmd` carries the type.
  - `phy_len` carries the byte count minus one.
  - `phy_addr` carries the address.
  - `phy_wdata` carries the write bytes. Byte i sits at bits [8i+7:8i], and bytes at or above the count are zero. For a read (type bit 0 = 1), the whole word is zero.
- R6: For a read that ends OK, `rsp_rdata` holds the PHY read word, with bytes at or above the count forced to zero. For writes, and for any result other than OK, `rsp_rdata` is zero.
- R7: Every attempt begins with a one-cycle `phy_chan_rst` pulse. The first attempt issues `phy_start` in the next cycle. Each later attempt puts exactly BACKOFF_US microseconds between the reset pulse and the start pulse.
- R8: An attempt succeeds only when `phy_err` is zero in the cycle `phy_done` is high. At most MAX_TRIES attempts are made. If every one of them fails, the response is REMOTE_ERROR (code 3). Success gives OK (code 0).
- R9: If `phy_done` does not arrive within WAIT_US microseconds of a start pulse, the response is REMOTE_ERROR and no further attempt is made.
- R10: A `phy_done` that arrives in the final cycle of the done wait counts as completion, not as a timeout.
- R11: The response is a single-cycle `rsp_valid`, and `phy_own_req` is low in that cycle whatever the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Block idle, command taken |
| req_type | input | 4 | Command type, bit 0 set for read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, byte i at [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 2 | 0 OK, 1 BUSY, 2 NO_SINK, 3 REMOTE_ERROR |
| rsp_rdata | output | 128 | Read bytes, masked to the count |
| phy_busy | input | 1 | Previous activity still busy or pending |
| phy_own_req | output | 1 | Channel ownership request |
| phy_own_gnt | input | 1 | Channel ownership granted |
| phy_sink | input | 1 | Sink present |
| phy_chan_rst | output | 1 | Channel reset pulse |
| phy_start | output | 1 | Attempt start pulse |
| phy_cmd | output | 4 | Command type field |
| phy_addr | output | 20 | Address field |
| phy_len | output | 4 | Byte count minus one |
| phy_wdata | output | 128 | Staged write bytes |
| phy_done | input | 1 | Attempt complete |
| phy_err | input | 8 | Error-status word, zero for success |
| phy_rdata | input | 128 | Read bytes from the PHY |

## Verification
The collision that matters is between completion of an attempt and expiry of the done timeout, because both are decided in the last cycle of the wait. The PHY model in the bench is given a done delay that lands in exactly that final cycle, and in a second run one cycle later. The first run must end OK after a single attempt. The second must end REMOTE_ERROR with no retry. Retries themselves are judged by counting start pulses and measuring the spacing between reset and start against the back-off.

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter int CLK_PER_US = 250,
  parameter int WAIT_US    = 1000,
  parameter int BACKOFF_US = 400,
  parameter int MAX_TRIES  = 32,
  parameter int BYTES      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_type,
  input  logic [19:0]           req_addr,
  input  logic [$clog2(BYTES+1)-1:0] req_len,
  input  logic [8*BYTES-1:0]    req_wdata,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_code,
  output logic [8*BYTES-1:0]    rsp_rdata,
  input  logic                  phy_busy,
  output logic                  phy_own_req,
  input  logic                  phy_own_gnt,
  input  logic                  phy_sink,
  output logic                  phy_chan_rst,
  output logic                  phy_start,
  output logic [3:0]            phy_cmd,
  output logic [19:0]           phy_addr,
  output logic [$clog2(BYTES+1)-2:0] phy_len,
  output logic [8*BYTES-1:0]    phy_wdata,
  input  logic                  phy_done,
  input  logic [7:0]            phy_err,
  input  logic [8*BYTES-1:0]    phy_rdata
);
  localparam int DW = 8 * BYTES;
  localparam int LW = $clog2(BYTES + 1);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int MW = (WAIT_US > BACKOFF_US) ? WAIT_US : BACKOFF_US;
  localparam int UW = $clog2(MW + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_QUIET, S_GRANT, S_SINK, S_RST, S_BACK, S_START, S_WDONE, S_RESP
  } st_t;

  localparam logic [1:0] C_OK = 2'd0, C_BUSY = 2'd1, C_NOSINK = 2'd2, C_REMERR = 2'd3;

  st_t             state, nxt;
  logic [PW-1:0]   pre;
  logic [UW-1:0]   us;
  logic [TW-1:0]   tries;
  logic [1:0]      code, code_d;
  logic [3:0]      cmd;
  logic [19:0]     addr;
  logic [LW-1:0]   len;
  logic [DW-1:0]   stage;
  logic [LW-1:0]   len_m1;

  function automatic logic [DW-1:0] keep(input logic [DW-1:0] d, input logic [LW-1:0] n);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < BYTES; i++)
      if (i < int'(n)) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  wire tick     = (pre == PW'(CLK_PER_US - 1));
  wire wait_exp = tick && (us == UW'(WAIT_US - 1));
  wire back_exp = tick && (us == UW'(BACKOFF_US - 1));
  wire ok_done  = phy_done && (phy_err == 8'd0);
  wire last_try = (tries == TW'(MAX_TRIES - 1));

  always_comb begin
    nxt    = state;
    code_d = C_OK;
    case (state)
      S_IDLE:  if (req_valid) nxt = S_QUIET;
      S_QUIET: if (!phy_busy) nxt = S_GRANT;
               else if (wait_exp) begin nxt = S_RESP; code_d = C_BUSY; end
      S_GRANT: if (phy_own_gnt) nxt = S_SINK;
               else if (wait_exp) begin nxt = S_RESP; code_d = C_BUSY; end
      S_SINK:  if (phy_sink) nxt = S_RST;
               else begin nxt = S_RESP; code_d = C_NOSINK; end
      S_RST:   nxt = (tries != '0) ? S_BACK : S_START;
      S_BACK:  if (back_exp) nxt = S_START;
      S_START: nxt = S_WDONE;
      S_WDONE: if (phy_done) begin
                 if (ok_done) begin nxt = S_RESP; code_d = C_OK; end
                 else if (last_try) begin nxt = S_RESP; code_d = C_REMERR; end
                 else nxt = S_RST;
               end else if (wait_exp) begin nxt = S_RESP; code_d = C_REMERR; end
      S_RESP:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pre   <= '0;
      us    <= '0;
      tries <= '0;
      code  <= C_OK;
      cmd   <= '0;
      addr  <= '0;
      len   <= '0;
      stage <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        pre <= '0;
        us  <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) us <= us + 1'b1;
      end
      if (state == S_IDLE && req_valid) begin
        cmd   <= req_type;
        addr  <= req_addr;
        len   <= req_len;
        stage <= req_type[0] ? '0 : keep(req_wdata, req_len);
      end
      if (state == S_SINK) tries <= '0;
      if (state == S_WDONE && phy_done && !ok_done) tries <= tries + 1'b1;
      if (state == S_WDONE && ok_done && cmd[0]) stage <= keep(phy_rdata, len);
      if (nxt == S_RESP && state != S_RESP) code <= code_d;
    end
  end

  assign len_m1       = len - LW'(1);
  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_RESP);
  assign rsp_code     = code;
  assign rsp_rdata    = (cmd[0] && code == C_OK) ? stage : '0;
  assign phy_own_req  = (state inside {S_GRANT, S_SINK, S_RST, S_BACK, S_START, S_WDONE});
  assign phy_chan_rst = (state == S_RST);
  assign phy_start    = (state == S_START);
  assign phy_cmd      = cmd;
  assign phy_addr     = addr;
  assign phy_len      = len_m1[LW-2:0];
  assign phy_wdata    = stage;

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r11_release_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !phy_own_req);
  a_r7_start_after_prep: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |-> ($past(phy_chan_rst) || $past(state == S_BACK)));
  a_r8_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |-> (tries < TW'(MAX_TRIES)));
  a_r4_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_start || phy_chan_rst) |-> phy_own_req);
  a_r2_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_QUIET && phy_busy && wait_exp) |=> (rsp_valid && rsp_code == C_BUSY));
endmodule

// File: tb/tb_aux_xact_seq.sv
module tb_aux_xact_seq;
  localparam int C  = 3;
  localparam int W  = 50;
  localparam int B  = 8;
  localparam int MT = 32;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [3:0]      req_type = '0;
  logic [19:0]     req_addr = '0;
  logic [4:0]      req_len = 5'd1;
  logic [DW-1:0]   req_wdata = '0;
  logic            rsp_valid;
  logic [1:0]      rsp_code;
  logic [DW-1:0]   rsp_rdata;
  logic            phy_busy = 1'b0;
  logic            phy_own_req;
  logic            phy_own_gnt = 1'b0;
  logic            phy_sink = 1'b1;
  logic            phy_chan_rst, phy_start;
  logic [3:0]      phy_cmd;
  logic [19:0]     phy_addr;
  logic [3:0]      phy_len;
  logic [DW-1:0]   phy_wdata;
  logic            phy_done = 1'b0;
  logic [7:0]      phy_err = '0;
  logic [DW-1:0]   phy_rdata = '0;

  aux_xact_seq #(.CLK_PER_US(C), .WAIT_US(W), .BACKOFF_US(B), .MAX_TRIES(MT), .BYTES(16)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_type, .req_addr, .req_len, .req_wdata,
    .rsp_valid, .rsp_code, .rsp_rdata, .phy_busy, .phy_own_req, .phy_own_gnt, .phy_sink,
    .phy_chan_rst, .phy_start, .phy_cmd, .phy_addr, .phy_len, .phy_wdata,
    .phy_done, .phy_err, .phy_rdata);

  int n_chk = 0, n_bad = 0;

  // PHY model knobs
  int          m_busy_left = 0;
  int          m_gnt_delay = 0;
  int          m_done_delay = 4;
  int          m_fails = 0;
  logic [7:0]  m_err = 8'h10;
  logic [DW-1:0] m_rdata = '0;
  // PHY model observations
  int          starts = 0, resets = 0, cyc = 0, last_rst = 0, gnt_cnt = 0, dcnt = 0;
  int          gap0 = -1, gap1 = -1;
  logic [3:0]  s_cmd;
  logic [19:0] s_addr;
  logic [3:0]  s_len;
  logic [DW-1:0] s_wdata;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    phy_busy <= (m_busy_left > 0);
    if (m_busy_left > 0 && m_busy_left < 1000000) m_busy_left <= m_busy_left - 1;
    if (phy_own_req) gnt_cnt <= gnt_cnt + 1; else gnt_cnt <= 0;
    phy_own_gnt <= phy_own_req && (gnt_cnt >= m_gnt_delay);
    if (phy_chan_rst) begin resets <= resets + 1; last_rst <= cyc; end
    phy_done <= 1'b0;
    if (phy_start) begin
      starts <= starts + 1;
      if (starts == 0) gap0 <= cyc - last_rst;
      if (starts == 1) gap1 <= cyc - last_rst;
      s_cmd <= phy_cmd; s_addr <= phy_addr; s_len <= phy_len; s_wdata <= phy_wdata;
      dcnt <= m_done_delay;
    end else if (dcnt > 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) begin
        phy_done  <= 1'b1;
        phy_err   <= (starts <= m_fails) ? m_err : 8'h00;
        phy_rdata <= m_rdata;
      end
    end
  end

  function automatic logic [DW-1:0] bytes_upto(input logic [DW-1:0] d, input int n);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < 16; i++) if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [1:0]    got_code;
  logic [DW-1:0] got_rdata;
  int            got_lat;
  logic          ready_mid, own_at_rsp;

  task automatic run(input logic [3:0] t, input logic [19:0] a, input int n, input logic [DW-1:0] wd);
    int k = 0;
    starts = 0; resets = 0; gap0 = -1; gap1 = -1;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_len = 5'(n); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ready_mid = req_ready;
    while (!rsp_valid && k < 100000) begin @(negedge clk); k++; end
    got_lat = k + 1;
    got_code = rsp_code; got_rdata = rsp_rdata; own_at_rsp = phy_own_req;
    @(negedge clk);
  endtask

  task automatic dflt();
    m_busy_left = 0; m_gnt_delay = 2; phy_sink = 1'b1; m_done_delay = 4; m_fails = 0; m_err = 8'h10;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog R11 actual=hung expected=response");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", DW'(req_ready), DW'(1));
    check("R11 no rsp after reset", DW'({rsp_valid, phy_own_req, phy_start}), DW'(0));

    // R2: busy never clears
    dflt(); m_busy_left = 2000000;
    run(4'h9, 20'h1, 4, '0);
    check("R2 busy code", DW'(got_code), DW'(1));
    check("R2 no start", DW'(starts), DW'(0));
    check("R2 wait length", DW'(got_lat >= W*C && got_lat <= W*C + 3), DW'(1));
    check("R1 ready low while busy", DW'(ready_mid), DW'(0));
    m_busy_left = 0; repeat (3) @(negedge clk);

    // R3: grant never arrives, busy briefly
    dflt(); m_busy_left = 10; m_gnt_delay = 1000000;
    run(4'h8, 20'h2, 2, '1);
    check("R3 grant timeout code", DW'(got_code), DW'(1));
    check("R11 own released at rsp", DW'(own_at_rsp), DW'(0));
    check("R3 no start", DW'(starts), DW'(0));

    // R4: no sink
    dflt(); phy_sink = 1'b0;
    run(4'h9, 20'h3, 1, '0);
    check("R4 no sink code", DW'(got_code), DW'(2));
    check("R4 no start", DW'(starts + resets), DW'(0));

    // R5 / R7: full write
    dflt();
    begin
      logic [DW-1:0] wd = rnd128();
      run(4'h8, 20'hABCDE, 16, wd);
      check("R8 write ok", DW'(got_code), DW'(0));
      check("R5 cmd field", DW'(s_cmd), DW'(4'h8));
      check("R5 len field", DW'(s_len), DW'(15));
      check("R5 addr field", DW'(s_addr), DW'(20'hABCDE));
      check("R5 write bytes", s_wdata, wd);
      check("R6 write gives zero rdata", got_rdata, '0);
      check("R7 first attempt gap", DW'(gap0), DW'(1));
    end

    // R6: single byte read
    dflt(); m_rdata = rnd128();
    run(4'h9, 20'h00010, 1, '1);
    check("R6 read one byte", got_rdata, bytes_upto(m_rdata, 1));
    check("R5 read stages zero", s_wdata, '0);
    check("R5 len field one", DW'(s_len), DW'(0));

    // R7 / R8: two failures then success
    dflt(); m_fails = 2; m_rdata = rnd128();
    run(4'h9, 20'h44, 5, '0);
    check("R8 ok after retries", DW'(got_code), DW'(0));
    check("R8 attempt count", DW'(starts), DW'(3));
    check("R7 reset per attempt", DW'(resets), DW'(3));
    check("R7 backoff gap", DW'(gap1), DW'(B*C + 1));
    check("R6 read five bytes", got_rdata, bytes_upto(m_rdata, 5));

    // R8: all attempts fail
    dflt(); m_fails = MT; m_err = 8'h01;
    run(4'h9, 20'h55, 8, '0);
    check("R8 exhausted code", DW'(got_code), DW'(3));
    check("R8 exhausted count", DW'(starts), DW'(MT));
    check("R6 zero on failure", got_rdata, '0);

    // R8: last attempt succeeds
    dflt(); m_fails = MT - 1; m_err = 8'h80;
    run(4'h8, 20'h66, 3, '1);
    check("R8 last try ok", DW'(got_code), DW'(0));
    check("R8 last try count", DW'(starts), DW'(MT));

    // R9: done one cycle too late
    dflt(); m_done_delay = W*C + 1;
    run(4'h9, 20'h77, 2, '0);
    check("R9 done timeout code", DW'(got_code), DW'(3));
    check("R9 no retry", DW'(starts), DW'(1));
    repeat (4) @(negedge clk);

    // R10: done in the final cycle
    dflt(); m_done_delay = W*C; m_rdata = rnd128();
    run(4'h9, 20'h78, 16, '0);
    check("R10 done on last cycle ok", DW'(got_code), DW'(0));
    check("R10 single attempt", DW'(starts), DW'(1));
    check("R10 read data", got_rdata, m_rdata);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [3:0] t = 4'($urandom());
      int n = 1 + ($urandom() % 16);
      logic [19:0] a = 20'($urandom());
      logic [DW-1:0] wd = rnd128();
      dflt(); m_fails = $urandom() % 3; m_done_delay = 1 + ($urandom() % 20);
      m_gnt_delay = $urandom() % 6; m_rdata = rnd128();
      run(t, a, n, wd);
      check("R8 random code", DW'(got_code), DW'(0));
      check("R8 random attempts", DW'(starts), DW'(m_fails + 1));
      check("R5 random fields", DW'({s_cmd, s_addr, s_len}), DW'({t, a, 4'(n - 1)}));
      check("R5 random wdata", s_wdata, t[0] ? '0 : bytes_upto(wd, n));
      check("R6 random rdata", got_rdata, t[0] ? bytes_upto(m_rdata, n) : '0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule